// File: doc/BRIEF.md
# Parallel Bus Target Read Sequencer

This block is the target end of a narrow, eight-bit parallel peripheral bus. It serves one read transaction at a time. It waits to be selected on its own ID. It then collects a command from the initiator and streams the requested number of data bytes out of a local first-word-fall-through buffer. It finishes by returning a good status byte and a command-complete message, and then lets go of the bus.

Every bus input is asynchronous to the block clock and passes through a two-flop synchroniser. The current phase is shown on three lines: control/data (`cd_o`), direction (`io_o`, high means target to initiator) and message (`msg_o`). Each byte, in either direction, moves under a four-phase REQ/ACK interlock. All pins here are active-high logic levels. Any open-collector inversion at the pads lies outside the block.

The command format is as follows. Bits [3:0] of the first command byte give the number of further command bytes, and bits [7:4] carry the opcode. The last further byte gives the number of data bytes to return. A command with no further bytes asks for zero data bytes.

Top module: `bus_target_seq`

## Requirements
- R1: During and after reset, with no selection, `bsy_o`, `req_o`, `cd_o`, `io_o`, `msg_o`, `db_oe_o`, `buf_rd_o` and `cmd_strobe_o` are all low.
- R2: The target raises `bsy_o` only when `bus_sel_i` is high, `bus_bsy_i` is low and bit `MY_ID` of `bus_db_i` is set. Selection with the ID bit clear, or with `bus_bsy_i` high, is ignored.
- R3: After `bus_sel_i` falls, command bytes are taken with {cd,io,msg} = {1,0,0}. Each byte latched on ACK appears on `cmd_byte_o` with a one-cycle `cmd_strobe_o` pulse, in bus order.
- R4: The low nibble of the first command byte sets how many more command bytes are taken. The last of those bytes is the data byte count, or the count is zero if there are none.
- R5: Data-in bytes carry {cd,io,msg} = {0,1,0}. They come from `buf_data_i` in buffer order, with exactly one `buf_rd_o` pulse per byte. `db_o` is stable for as long as `req_o` is high.
- R6: When the data byte count is zero, the data-in phase is skipped and no `buf_rd_o` pulse occurs.
- R7: The status byte is 0x00 with {cd,io,msg} = {1,1,0}.
- R8: The message byte is 0x00 (command complete) with {cd,io,msg} = {1,1,1}. After its ACK is negated, `bsy_o` falls. Whenever `bsy_o` is low, `req_o`, `cd_o`, `io_o` and `msg_o` are low.
- R9: `req_o` rises only after ACK has been seen low and falls only after ACK has been seen high. Each decision uses ACK as sampled three clocks earlier through the synchroniser.
- R10: `db_oe_o` is high only while `io_o` and `bsy_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_bsy_i | input | 1 | Bus busy line as seen by the target |
| bus_sel_i | input | 1 | Bus select line |
| bus_ack_i | input | 1 | Initiator acknowledge |
| bus_db_i | input | 8 | Data lines from the initiator |
| bsy_o | output | 1 | Target drives busy |
| req_o | output | 1 | Target request |
| cd_o | output | 1 | Control/data phase line |
| io_o | output | 1 | Direction line, high for target to initiator |
| msg_o | output | 1 | Message phase line |
| db_o | output | 8 | Data lines driven by the target |
| db_oe_o | output | 1 | Output enable for `db_o` |
| buf_data_i | input | 8 | Head byte of the local read buffer |
| buf_rd_o | output | 1 | Pops the buffer head |
| cmd_byte_o | output | 8 | Last latched command byte |
| cmd_strobe_o | output | 1 | One-cycle pulse, new command byte |

## Verification
The hardest case to reach is the REQ/ACK interlock under a slow initiator. A wrong design could raise REQ again while a stale ACK is still in the synchroniser. To reach it, the bench stretches its ACK delay from zero to several clocks across transactions and times REQ against the most recent ACK fall on every clock. A zero-count command checks the phase skip. A long transfer runs past the width of the command-length nibble.

// File: rtl/bus_target_seq.sv
module bus_target_seq #(
  parameter int DW    = 8,
  parameter int MY_ID = 5,
  parameter int NW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_bsy_i,
  input  logic          bus_sel_i,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_db_i,
  output logic          bsy_o,
  output logic          req_o,
  output logic          cd_o,
  output logic          io_o,
  output logic          msg_o,
  output logic [DW-1:0] db_o,
  output logic          db_oe_o,
  input  logic [DW-1:0] buf_data_i,
  output logic          buf_rd_o,
  output logic [DW-1:0] cmd_byte_o,
  output logic          cmd_strobe_o
);
  localparam int SW = DW + 3;
  localparam logic [DW-1:0] GOOD_STATUS = '0;
  localparam logic [DW-1:0] CMD_DONE    = '0;

  typedef enum logic [2:0] {S_IDLE, S_SELW, S_SETUP, S_REQ, S_REL} st_t;
  typedef enum logic [1:0] {P_CMD, P_DATA, P_STAT, P_MSG} ph_t;

  logic [SW-1:0] sy1, sy2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= {bus_bsy_i, bus_sel_i, bus_ack_i, bus_db_i};
      sy2 <= sy1;
    end

  logic          bsy_s, sel_s, ack_s;
  logic [DW-1:0] db_s;
  assign {bsy_s, sel_s, ack_s, db_s} = sy2;

  st_t           st;
  ph_t           ph;
  logic          first;
  logic [NW-1:0] cmd_left;
  logic [DW-1:0] data_left;
  logic [DW-1:0] dreg;

  logic in_phase, go_data, ph_done;
  assign in_phase = (st == S_SETUP) || (st == S_REQ) || (st == S_REL);
  assign ph_done  = (ph == P_CMD)  ? (cmd_left == '0) :
                    (ph == P_DATA) ? (data_left == '0) : 1'b1;
  assign go_data  = (st == S_REL) && !ack_s && data_left != '0 &&
                    ((ph == P_CMD && cmd_left == '0) || ph == P_DATA);

  assign bsy_o    = (st != S_IDLE);
  assign req_o    = (st == S_REQ);
  assign cd_o     = in_phase && (ph != P_DATA);
  assign io_o     = in_phase && (ph != P_CMD);
  assign msg_o    = in_phase && (ph == P_MSG);
  assign db_oe_o  = io_o;
  assign db_o     = dreg;
  assign buf_rd_o = go_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st           <= S_IDLE;
      ph           <= P_CMD;
      first        <= 1'b1;
      cmd_left     <= '0;
      data_left    <= '0;
      dreg         <= '0;
      cmd_byte_o   <= '0;
      cmd_strobe_o <= 1'b0;
    end else begin
      cmd_strobe_o <= 1'b0;
      case (st)
        S_IDLE:
          if (sel_s && !bsy_s && db_s[MY_ID]) begin
            st        <= S_SELW;
            ph        <= P_CMD;
            first     <= 1'b1;
            cmd_left  <= '0;
            data_left <= '0;
            dreg      <= '0;
          end
        S_SELW:
          if (!sel_s) st <= S_SETUP;
        S_SETUP:
          if (!ack_s) st <= S_REQ;
        S_REQ:
          if (ack_s) begin
            st <= S_REL;
            case (ph)
              P_CMD: begin
                cmd_byte_o   <= db_s;
                cmd_strobe_o <= 1'b1;
                first        <= 1'b0;
                if (first) begin
                  cmd_left  <= db_s[NW-1:0];
                  data_left <= '0;
                end else begin
                  cmd_left  <= cmd_left - 1'b1;
                  data_left <= db_s;
                end
              end
              P_DATA:  data_left <= data_left - 1'b1;
              default: ;
            endcase
          end
        S_REL:
          if (!ack_s) begin
            st <= S_SETUP;
            if (go_data) begin
              ph   <= P_DATA;
              dreg <= buf_data_i;
            end else if (ph_done) begin
              case (ph)
                P_CMD, P_DATA: begin
                  ph   <= P_STAT;
                  dreg <= GOOD_STATUS;
                end
                P_STAT: begin
                  ph   <= P_MSG;
                  dreg <= CMD_DONE;
                end
                default: begin
                  st   <= S_IDLE;
                  ph   <= P_CMD;
                  dreg <= '0;
                end
              endcase
            end
          end
        default: st <= S_IDLE;
      endcase
    end
endmodule

module bus_target_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_ack_i,
  input logic          bsy_o,
  input logic          req_o,
  input logic          cd_o,
  input logic          io_o,
  input logic          msg_o,
  input logic [DW-1:0] db_o,
  input logic          db_oe_o,
  input logic          buf_rd_o
);
  a_r9_req_rise_after_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> !$past(bus_ack_i, 3));

  a_r9_req_fall_after_ack_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_o) |-> $past(bus_ack_i, 3));

  a_r5_db_stable_under_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && $past(req_o)) |-> $stable(db_o));

  a_r10_oe_only_outbound: assert property (@(posedge clk) disable iff (!rst_n)
    db_oe_o |-> (io_o && bsy_o));

  a_r8_quiet_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    !bsy_o |-> !(req_o || cd_o || io_o || msg_o));

  a_r8_msg_phase_lines: assert property (@(posedge clk) disable iff (!rst_n)
    msg_o |-> (cd_o && io_o));

  a_r5_pop_in_connection: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_o |-> (bsy_o && !req_o));
endmodule

bind bus_target_seq bus_target_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ack_i(bus_ack_i), .bsy_o(bsy_o),
  .req_o(req_o), .cd_o(cd_o), .io_o(io_o), .msg_o(msg_o), .db_o(db_o),
  .db_oe_o(db_oe_o), .buf_rd_o(buf_rd_o)
);

// File: tb/test_bus_target_seq.sv
module test_bus_target_seq;
  localparam int ID = 5;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_bsy_i = 0, bus_sel_i = 0, bus_ack_i = 0;
  logic [7:0] bus_db_i = 0;
  logic       bsy_o, req_o, cd_o, io_o, msg_o, db_oe_o, buf_rd_o, cmd_strobe_o;
  logic [7:0] db_o, buf_data_i, cmd_byte_o;

  always #5 clk = ~clk;

  int vectors = 0, fails = 0;
  int rd_ptr = 0, ack_low = 0;
  logic prev_req = 0;
  logic [7:0] cmd_q[$];

  assign buf_data_i = 8'((rd_ptr * 37 + 11) & 255);

  bus_target_seq #(.MY_ID(ID)) i_bus_target_seq (.*);

  always @(posedge clk) begin
    if (buf_rd_o) rd_ptr <= rd_ptr + 1;
    if (cmd_strobe_o) cmd_q.push_back(cmd_byte_o);
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // per-clock reference checks
  always @(negedge clk) if (rst_n) begin
    if (req_o && !prev_req) chk("R9", "ack low clocks before req rise", int'(ack_low >= 3), 1);
    if (!bsy_o) chk("R8", "lines idle while free", {req_o, cd_o, io_o, msg_o}, 0);
    if (db_oe_o) chk("R10", "oe implies io and bsy", {io_o, bsy_o}, 3);
    prev_req = req_o;
    ack_low = bus_ack_i ? 0 : ack_low + 1;
  end

  task automatic xfer(input logic [7:0] out_b, input int dly,
                      output logic [2:0] ph, output logic [7:0] in_b);
    while (!req_o) @(negedge clk);
    ph   = {cd_o, io_o, msg_o};
    in_b = db_o;
    if (!io_o) bus_db_i = out_b;
    repeat (dly) @(negedge clk);
    bus_ack_i = 1;
    while (req_o) @(negedge clk);
    repeat (dly) @(negedge clk);
    bus_ack_i = 0;
    bus_db_i  = 0;
  endtask

  task automatic select_me();
    @(negedge clk);
    bus_db_i  = 8'h80 | 8'(1 << ID);
    bus_sel_i = 1;
    for (int i = 0; i < 10 && !bsy_o; i++) @(negedge clk);
    chk("R2", "bsy on own id", bsy_o, 1);
    bus_sel_i = 0;
    bus_db_i  = 0;
  endtask

  task automatic txn(input int n_extra, input int count, input int dly);
    logic [2:0] ph;
    logic [7:0] b, exp_cmd[$];
    int start = rd_ptr;
    cmd_q.delete();
    select_me();
    exp_cmd.push_back(8'({4'hA, 4'(n_extra)}));
    for (int i = 1; i <= n_extra; i++)
      exp_cmd.push_back(i == n_extra ? 8'(count) : 8'(i * 17));
    foreach (exp_cmd[i]) begin
      xfer(exp_cmd[i], dly, ph, b);
      chk("R3", "command phase lines", ph, 3'b100);
    end
    for (int k = 0; k < count; k++) begin
      xfer(8'h00, dly, ph, b);
      chk("R5", "data-in phase lines", ph, 3'b010);
      chk("R5", "data byte", b, (start + k) * 37 + 11 & 255);
    end
    xfer(8'h00, dly, ph, b);
    chk("R6", "status follows data/command", ph, 3'b110);
    chk("R7", "status byte", b, 0);
    xfer(8'h00, dly, ph, b);
    chk("R8", "message phase lines", ph, 3'b111);
    chk("R8", "command complete byte", b, 0);
    for (int i = 0; i < 8 && bsy_o; i++) @(negedge clk);
    chk("R8", "bsy released", bsy_o, 0);
    chk("R3", "command byte count", cmd_q.size(), exp_cmd.size());
    foreach (exp_cmd[i])
      if (i < cmd_q.size()) chk("R4", "command byte", cmd_q[i], exp_cmd[i]);
    chk(count == 0 ? "R6" : "R5", "buffer pops", rd_ptr - start, count);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {bsy_o, req_o, cd_o, io_o, msg_o, db_oe_o, buf_rd_o, cmd_strobe_o}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", "outputs after reset", {bsy_o, req_o, cd_o, io_o, msg_o, db_oe_o, buf_rd_o, cmd_strobe_o}, 0);
    // wrong id
    bus_db_i = 8'h84; bus_sel_i = 1;
    repeat (10) @(negedge clk);
    chk("R2", "other id ignored", bsy_o, 0);
    // bus busy
    bus_db_i = 8'h80 | 8'(1 << ID); bus_bsy_i = 1;
    repeat (10) @(negedge clk);
    chk("R2", "selection while busy ignored", bsy_o, 0);
    bus_sel_i = 0; bus_bsy_i = 0; bus_db_i = 0;
    repeat (5) @(negedge clk);
    txn(2, 5, 0);
    txn(0, 0, 2);
    txn(1, 0, 1);
    txn(3, 3, 4);
    txn(1, 40, 0);
    txn(15, 7, 1);
    txn(1, 255, 0);
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule